// File: doc/BRIEF.md
# Serial Link Initialization Controller

This block runs connection setup and teardown for one end of a point-to-point data-strobe serial link. After reset it holds the link quiet for a fixed settling time. It then listens for a longer window with the receiver enabled. After that it waits for a start command from the host, exchanges NULL and flow-control characters with the far end, and enters the run state. The receiver, the transmitter and the packet queues are separate blocks. This controller only enables them and is told by them what arrived or what was sent.

The controller also keeps the credit in both directions. One counter holds how many data characters the local transmitter may still send. The other holds how many characters the far end was told it may send. The controller asks the transmitter for a flow-control character through a valid/ready pair. `fct_valid` stays high while the credit rule allows another grant and the link is connecting or running. The grant is counted only in a cycle where `fct_valid` and `fct_ready` are both high. If the link leaves those states, `fct_valid` drops without a handshake. All other pins are plain levels or one-cycle pulses.

Top module: `dslink_ctrl`

## Requirements
- R1: After `rst` is released the link stays in its settling state for RST_CYC clock cycles (64 at the default 10 MHz, which is 6.4 us), with `rx_en` and `tx_en` low; `rx_en` rises at the edge that ends that count.
- R2: The listening window that follows lasts WAIT_CYC = 2*RST_CYC cycles, with `rx_en` high and `tx_en` low. A received flow-control or data character, or any receiver error, in that window sends the link back to settling (`rx_en` low after the next edge).
- R3: In the idle-ready state with `link_dis` low, `started` rises after the next edge if `link_start` is high, or if `auto_start` is high and a NULL has been seen since settling ended. With neither, the link stays idle.
- R4: `link_dis` high keeps the link in idle-ready whatever the start inputs are. In started, connecting or run it sends the link to settling with no error pulse.
- R5: Started moves to connecting once a NULL has been seen, and connecting moves to run on a received flow-control character. If either state lasts WAIT_CYC cycles without advancing, the link returns to settling.
- R6: In run, `rx_err_disc`, `rx_err_par` or `rx_err_esc` sends the link to settling after the next edge. The matching `err_disc`, `err_par` or `err_esc` output is high for exactly that one cycle.
- R7: Each flow-control character received while connecting or running adds FCT_STEP (8) to transmit credit. Each `tx_nchar_done` with non-zero credit subtracts 1. If both happen in one cycle the net change is +7. `tx_ok` is high exactly when running with credit above zero.
- R8: A flow-control character received in run that would take credit plus 8 minus the same-cycle send above CRED_CAP (56) raises `err_cred` for one cycle and sends the link to settling.
- R9: `fct_valid` is high exactly when connecting or running, granted+8 <= 56 and `rx_room` >= granted+8. A handshake adds 8 to granted. Each `rx_nchar` while granted is non-zero subtracts 1. Both in one cycle give +7. Granted is cleared in settling.
- R10: At most one of `started`, `connecting`, `running` is high, and `tx_en` is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_start | input | 1 | Host command to start from idle-ready |
| auto_start | input | 1 | Start from idle-ready once a NULL has been seen |
| link_dis | input | 1 | Disable; overrides both starts and drops a live link |
| rx_null | input | 1 | Pulse: receiver decoded a NULL |
| rx_fct | input | 1 | Pulse: receiver decoded a flow-control character |
| rx_nchar | input | 1 | Pulse: receiver delivered a data or end-of-packet character |
| rx_err_disc | input | 1 | Pulse: receiver detected a disconnect |
| rx_err_par | input | 1 | Pulse: receiver detected a parity error |
| rx_err_esc | input | 1 | Pulse: receiver detected a bad escape sequence |
| rx_room | input | ROOM_W | Free receive queue slots, saturating at 63 |
| tx_nchar_done | input | 1 | Pulse: transmitter sent one data character |
| fct_valid | output | 1 | Request to send one flow-control character |
| fct_ready | input | 1 | Transmitter accepts the flow-control request |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| tx_ok | output | 1 | Data characters may be sent |
| started | output | 1 | Link in started state |
| connecting | output | 1 | Link in connecting state |
| running | output | 1 | Link in run state |
| err_disc | output | 1 | One-cycle disconnect error pulse |
| err_par | output | 1 | One-cycle parity error pulse |
| err_esc | output | 1 | One-cycle escape error pulse |
| err_cred | output | 1 | One-cycle credit error pulse |

## Verification
Two pairs of events can fall in the same cycle, and each needs its own check. The first pair is a received flow-control character and a sent data character, which change transmit credit together. The second pair is a flow-control handshake and a received data character, which change the granted count together. Random run-state traffic drives both members of each pair at once in many cycles. A bench model decides whether `tx_ok`, `fct_valid` and `err_cred` follow the net +7 rule. Directed steps then test the +7 case at one unit of credit, and the exact room threshold after a combined grant-and-receive cycle.

// File: rtl/dslink_pkg.sv
package dslink_pkg;
  typedef enum logic [2:0] {
    LS_SETTLE  = 3'd0,
    LS_LISTEN  = 3'd1,
    LS_IDLE    = 3'd2,
    LS_STARTED = 3'd3,
    LS_CONNECT = 3'd4,
    LS_RUN     = 3'd5
  } link_state_t;

  localparam int ERR_N  = 4;
  localparam int E_DISC = 0;
  localparam int E_PAR  = 1;
  localparam int E_ESC  = 2;
  localparam int E_CRED = 3;
endpackage

// File: rtl/dslink_timer.sv
module dslink_timer #(
  parameter int RST_CYC  = 64,
  parameter int WAIT_CYC = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic rst_done,
  output logic wait_done
);
  localparam int TW = $clog2(WAIT_CYC + 1);
  localparam logic [TW-1:0] RST_LAST  = TW'(RST_CYC - 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(WAIT_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt != WAIT_LAST) cnt <= cnt + 1'b1;
  end

  assign rst_done  = (cnt == RST_LAST);
  assign wait_done = (cnt == WAIT_LAST);

  // R5: the counter never moves past its saturation point
  assert_timer_sat_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt == WAIT_LAST && !restart) |=> (cnt == WAIT_LAST));
endmodule

// File: rtl/dslink_credit.sv
module dslink_credit #(
  parameter int FCT_STEP = 8,
  parameter int CRED_CAP = 56,
  parameter int ROOM_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              live,
  input  logic              in_run,
  input  logic              rx_fct,
  input  logic              tx_sent,
  input  logic              rx_nchar,
  input  logic [ROOM_W-1:0] rx_room,
  input  logic              fct_ready,
  output logic              fct_valid,
  output logic              tx_ok,
  output logic              cred_err
);
  localparam int CW = $clog2(CRED_CAP + 1);

  logic [CW-1:0] tx_cred;
  logic [CW-1:0] rx_grant;
  logic          sent_eff;
  logic          take;
  logic          dec;
  int            tx_sum;
  int            grant_next;

  assign sent_eff = tx_sent && (tx_cred != '0);
  assign tx_sum   = int'(tx_cred) + FCT_STEP - (sent_eff ? 1 : 0);
  assign cred_err = in_run && rx_fct && (tx_sum > CRED_CAP);
  assign tx_ok    = in_run && (tx_cred != '0);

  always_ff @(posedge clk) begin
    if (rst || clear) tx_cred <= '0;
    else if (live && rx_fct && !cred_err) tx_cred <= CW'(tx_sum);
    else if (sent_eff) tx_cred <= tx_cred - 1'b1;
  end

  assign grant_next = int'(rx_grant) + FCT_STEP;
  assign fct_valid  = live && (grant_next <= CRED_CAP) && (int'(rx_room) >= grant_next);
  assign take       = fct_valid && fct_ready;
  assign dec        = live && rx_nchar && (rx_grant != '0);

  always_ff @(posedge clk) begin
    if (rst || clear) rx_grant <= '0;
    else if (take || dec)
      rx_grant <= CW'(int'(rx_grant) + (take ? FCT_STEP : 0) - (dec ? 1 : 0));
  end

  assert_credit_cap_R8: assert property (@(posedge clk) disable iff (rst)
    int'(tx_cred) <= CRED_CAP);
  assert_grant_cap_R9: assert property (@(posedge clk) disable iff (rst)
    int'(rx_grant) <= CRED_CAP);
  assert_fct_live_R9: assert property (@(posedge clk) disable iff (rst)
    fct_valid |-> live);
  assert_ok_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (clear) |=> !tx_ok);
endmodule

// File: rtl/dslink_fsm.sv
module dslink_fsm
  import dslink_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             link_start,
  input  logic             auto_start,
  input  logic             link_dis,
  input  logic             rx_null,
  input  logic             rx_fct,
  input  logic             rx_nchar,
  input  logic             rx_err_disc,
  input  logic             rx_err_par,
  input  logic             rx_err_esc,
  input  logic             cred_err,
  input  logic             rst_done,
  input  logic             wait_done,
  output link_state_t      st,
  output logic             restart,
  output logic [ERR_N-1:0] err_q
);
  link_state_t      nxt;
  logic             got_null;
  logic             null_seen;
  logic             rx_bad;
  logic             early;
  logic             go;
  logic [ERR_N-1:0] err_src;

  assign null_seen = got_null || rx_null;
  assign rx_bad    = rx_err_disc || rx_err_par || rx_err_esc;
  assign early     = rx_fct || rx_nchar;
  assign go        = !link_dis && (link_start || (auto_start && null_seen));

  always_comb begin
    nxt = st;
    case (st)
      LS_SETTLE:  if (rst_done) nxt = LS_LISTEN;
      LS_LISTEN:  if (rx_bad || early) nxt = LS_SETTLE;
                  else if (wait_done) nxt = LS_IDLE;
      LS_IDLE:    if (rx_bad || early) nxt = LS_SETTLE;
                  else if (go) nxt = LS_STARTED;
      LS_STARTED: if (link_dis || rx_bad || early || wait_done) nxt = LS_SETTLE;
                  else if (null_seen) nxt = LS_CONNECT;
      LS_CONNECT: if (link_dis || rx_bad || rx_nchar || wait_done) nxt = LS_SETTLE;
                  else if (rx_fct) nxt = LS_RUN;
      LS_RUN:     if (link_dis || rx_bad || cred_err) nxt = LS_SETTLE;
      default:    nxt = LS_SETTLE;
    endcase
  end

  assign restart = (nxt != st);

  always_ff @(posedge clk) begin
    if (rst) st <= LS_SETTLE;
    else st <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || st == LS_SETTLE) got_null <= 1'b0;
    else if (rx_null) got_null <= 1'b1;
  end

  assign err_src[E_DISC] = rx_err_disc;
  assign err_src[E_PAR]  = rx_err_par;
  assign err_src[E_ESC]  = rx_err_esc;
  assign err_src[E_CRED] = cred_err;

  for (genvar g = 0; g < ERR_N; g++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst) err_q[g] <= 1'b0;
      else err_q[g] <= (st == LS_RUN) && err_src[g];
    end

    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      err_q[g] |=> !err_q[g]);
    assert_err_settle_R6: assert property (@(posedge clk) disable iff (rst)
      err_q[g] |-> (st == LS_SETTLE));
  end

  assert_dis_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (st == LS_IDLE && link_dis) |=> (st != LS_STARTED));
  assert_run_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (st == LS_RUN && $past(st) != LS_RUN) |-> $past(st == LS_CONNECT));
endmodule

// File: rtl/dslink_ctrl.sv
module dslink_ctrl #(
  parameter int CLK_HZ   = 10_000_000,
  parameter int FCT_STEP = 8,
  parameter int CRED_CAP = 56,
  parameter int ROOM_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_start,
  input  logic              auto_start,
  input  logic              link_dis,
  input  logic              rx_null,
  input  logic              rx_fct,
  input  logic              rx_nchar,
  input  logic              rx_err_disc,
  input  logic              rx_err_par,
  input  logic              rx_err_esc,
  input  logic [ROOM_W-1:0] rx_room,
  input  logic              tx_nchar_done,
  output logic              fct_valid,
  input  logic              fct_ready,
  output logic              rx_en,
  output logic              tx_en,
  output logic              tx_ok,
  output logic              started,
  output logic              connecting,
  output logic              running,
  output logic              err_disc,
  output logic              err_par,
  output logic              err_esc,
  output logic              err_cred
);
  import dslink_pkg::*;

  localparam longint RST_RAW  = (longint'(CLK_HZ) * 64) / 10_000_000;
  localparam int     RST_CYC  = (RST_RAW < 1) ? 1 : int'(RST_RAW);
  localparam int     WAIT_CYC = 2 * RST_CYC;

  link_state_t      st;
  logic             restart;
  logic             rst_done;
  logic             wait_done;
  logic             cred_err;
  logic [ERR_N-1:0] err_q;

  dslink_timer #(.RST_CYC(RST_CYC), .WAIT_CYC(WAIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .restart(restart),
    .rst_done(rst_done), .wait_done(wait_done)
  );

  dslink_fsm u_fsm (
    .clk(clk), .rst(rst),
    .link_start(link_start), .auto_start(auto_start), .link_dis(link_dis),
    .rx_null(rx_null), .rx_fct(rx_fct), .rx_nchar(rx_nchar),
    .rx_err_disc(rx_err_disc), .rx_err_par(rx_err_par), .rx_err_esc(rx_err_esc),
    .cred_err(cred_err), .rst_done(rst_done), .wait_done(wait_done),
    .st(st), .restart(restart), .err_q(err_q)
  );

  dslink_credit #(.FCT_STEP(FCT_STEP), .CRED_CAP(CRED_CAP), .ROOM_W(ROOM_W)) u_credit (
    .clk(clk), .rst(rst),
    .clear(st == LS_SETTLE),
    .live(st == LS_CONNECT || st == LS_RUN),
    .in_run(st == LS_RUN),
    .rx_fct(rx_fct), .tx_sent(tx_nchar_done), .rx_nchar(rx_nchar),
    .rx_room(rx_room), .fct_ready(fct_ready),
    .fct_valid(fct_valid), .tx_ok(tx_ok), .cred_err(cred_err)
  );

  assign started    = (st == LS_STARTED);
  assign connecting = (st == LS_CONNECT);
  assign running    = (st == LS_RUN);
  assign rx_en      = (st != LS_SETTLE);
  assign tx_en      = started || connecting || running;
  assign err_disc   = err_q[E_DISC];
  assign err_par    = err_q[E_PAR];
  assign err_esc    = err_q[E_ESC];
  assign err_cred   = err_q[E_CRED];

  assert_status_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({started, connecting, running}));
  assert_tx_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !rx_en |-> !tx_en);
endmodule

// File: tb/sim_dslink_ctrl.sv
module sim_dslink_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_start = 0, auto_start = 0, link_dis = 0;
  logic rx_null = 0, rx_fct = 0, rx_nchar = 0;
  logic rx_err_disc = 0, rx_err_par = 0, rx_err_esc = 0;
  logic [5:0] rx_room = '0;
  logic tx_nchar_done = 0, fct_ready = 0;
  logic fct_valid, rx_en, tx_en, tx_ok, started, connecting, running;
  logic err_disc, err_par, err_esc, err_cred;

  int errors = 0;
  int checks = 0;
  int c_m = 0;
  int g_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dslink_ctrl u0 (
    .clk(clk), .rst(rst), .link_start(link_start), .auto_start(auto_start),
    .link_dis(link_dis), .rx_null(rx_null), .rx_fct(rx_fct), .rx_nchar(rx_nchar),
    .rx_err_disc(rx_err_disc), .rx_err_par(rx_err_par), .rx_err_esc(rx_err_esc),
    .rx_room(rx_room), .tx_nchar_done(tx_nchar_done), .fct_valid(fct_valid),
    .fct_ready(fct_ready), .rx_en(rx_en), .tx_en(tx_en), .tx_ok(tx_ok),
    .started(started), .connecting(connecting), .running(running),
    .err_disc(err_disc), .err_par(err_par), .err_esc(err_esc), .err_cred(err_cred)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_fct_valid(input int g, input int room);
    return ((g + 8 <= 56) && (room >= g + 8)) ? 1 : 0;
  endfunction

  function automatic int cred_over(input int c, input int sent);
    return (c + 8 - sent > 56) ? 1 : 0;
  endfunction

  task automatic clear_inputs();
    rx_null = 0; rx_fct = 0; rx_nchar = 0;
    rx_err_disc = 0; rx_err_par = 0; rx_err_esc = 0;
    tx_nchar_done = 0; fct_ready = 0; rx_room = '0;
  endtask

  task automatic hold_reset(input logic ls, input logic as);
    clear_inputs();
    link_dis = 0; link_start = ls; auto_start = as;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic bring_up();
    hold_reset(1'b1, 1'b0);
    for (int k = 0; k < 400 && !started; k++) @(negedge clk);
    rx_null = 1; @(negedge clk); rx_null = 0;
    rx_fct = 1;  @(negedge clk); rx_fct = 0;
    link_start = 0;
    c_m = 8; g_m = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // Reset state, R1 and R10
    repeat (2) @(negedge clk);
    chk("R1", "rx_en in reset", rx_en, 0);
    chk("R10", "tx_en in reset", tx_en, 0);

    // R1, R2, R3 timing with link_start held
    hold_reset(1'b1, 1'b0);
    repeat (63) @(negedge clk);
    chk("R1", "rx_en at cycle 63", rx_en, 0);
    @(negedge clk);
    chk("R1", "rx_en at cycle 64", rx_en, 1);
    chk("R2", "tx_en while listening", tx_en, 0);
    repeat (128) @(negedge clk);
    chk("R2", "started end of listening", started, 0);
    @(negedge clk);
    chk("R3", "started after link_start", started, 1);
    chk("R10", "tx_en in started", tx_en, 1);
    // R5 timeout in started
    repeat (127) @(negedge clk);
    chk("R5", "started before timeout", started, 1);
    @(negedge clk);
    chk("R5", "started after timeout", started, 0);
    chk("R5", "rx_en after timeout", rx_en, 0);

    // R2 premature character while listening
    hold_reset(1'b0, 1'b0);
    repeat (64) @(negedge clk);
    chk("R2", "rx_en listening", rx_en, 1);
    rx_fct = 1; @(negedge clk); rx_fct = 0;
    chk("R2", "rx_en after early fct", rx_en, 0);

    // R3 and R4 in idle-ready
    hold_reset(1'b0, 1'b0);
    repeat (195) @(negedge clk);
    chk("R3", "idle without start", started, 0);
    link_dis = 1; link_start = 1;
    repeat (3) @(negedge clk);
    chk("R4", "disable blocks start", started, 0);
    link_dis = 0;
    @(negedge clk);
    chk("R3", "start after disable drops", started, 1);

    hold_reset(1'b0, 1'b1);
    repeat (195) @(negedge clk);
    chk("R3", "auto_start waits for null", started, 0);
    rx_null = 1; @(negedge clk); rx_null = 0;
    chk("R3", "auto_start with null", started, 1);
    @(negedge clk);
    chk("R5", "connecting after null", connecting, 1);
    rx_fct = 1; @(negedge clk); rx_fct = 0;
    chk("R5", "running after fct", running, 1);
    chk("R7", "tx_ok with first credit", tx_ok, 1);
    link_dis = 1; @(negedge clk); link_dis = 0;
    chk("R4", "running after disable", running, 0);
    chk("R4", "no error pulse on disable", {err_disc, err_par, err_esc, err_cred}, 0);

    // R6 receiver errors in run
    bring_up();
    rx_err_par = 1; @(negedge clk); rx_err_par = 0;
    chk("R6", "err_par pulse", err_par, 1);
    chk("R6", "running after parity", running, 0);
    @(negedge clk);
    chk("R6", "err_par clears", err_par, 0);
    bring_up();
    rx_err_disc = 1; @(negedge clk); rx_err_disc = 0;
    chk("R6", "err_disc pulse", err_disc, 1);
    chk("R6", "only disc raised", {err_par, err_esc, err_cred}, 0);
    @(negedge clk);
    chk("R6", "err_disc clears", err_disc, 0);
    bring_up();
    rx_err_esc = 1; @(negedge clk); rx_err_esc = 0;
    chk("R6", "err_esc pulse", err_esc, 1);
    @(negedge clk);
    chk("R6", "err_esc clears", err_esc, 0);

    // R7 credit count with combined cycle
    bring_up();
    repeat (7) begin tx_nchar_done = 1; @(negedge clk); end
    tx_nchar_done = 1; rx_fct = 1; @(negedge clk); rx_fct = 0;
    repeat (7) @(negedge clk);
    tx_nchar_done = 0;
    chk("R7", "tx_ok after +7 then 7 sends", tx_ok, 1);
    tx_nchar_done = 1; @(negedge clk); tx_nchar_done = 0;
    chk("R7", "tx_ok at zero credit", tx_ok, 0);

    // R8 cap boundary
    bring_up();
    repeat (6) begin rx_fct = 1; @(negedge clk); end
    rx_fct = 0;
    chk("R8", "no error at 56", err_cred, 0);
    chk("R8", "running at 56", running, 1);
    rx_fct = 1; @(negedge clk); rx_fct = 0;
    chk("R8", "err_cred beyond 56", err_cred, 1);
    chk("R8", "running after credit error", running, 0);

    // R9 grant handshake
    bring_up();
    rx_room = 7; #1;
    chk("R9", "fct_valid room 7", fct_valid, 0);
    rx_room = 8; #1;
    chk("R9", "fct_valid room 8", fct_valid, 1);
    fct_ready = 1; @(negedge clk); fct_ready = 0; #1;
    chk("R9", "fct_valid room 8 granted 8", fct_valid, 0);
    rx_room = 16; #1;
    chk("R9", "fct_valid room 16", fct_valid, 1);
    fct_ready = 1; rx_nchar = 1; @(negedge clk);
    fct_ready = 0; rx_nchar = 0;
    rx_room = 22; #1;
    chk("R9", "fct_valid room 22 granted 15", fct_valid, 0);
    rx_room = 23; #1;
    chk("R9", "fct_valid room 23 granted 15", fct_valid, 1);

    // Random run-state traffic: R7, R8, R9
    bring_up();
    for (int i = 0; i < 2500; i++) begin
      int room, rdy, f, s, n, ev;
      @(negedge clk);
      chk("R7", "tx_ok random", tx_ok, (c_m > 0) ? 1 : 0);
      chk("R8", "running random", running, 1);
      room = $urandom % 64;
      rdy  = $urandom % 2;
      f    = (($urandom % 6) == 0) ? 1 : 0;
      s    = (c_m > 0 && ($urandom % 2) == 1) ? 1 : 0;
      n    = (g_m > 0 && ($urandom % 2) == 1) ? 1 : 0;
      rx_room = room[5:0]; fct_ready = rdy[0]; rx_fct = f[0];
      tx_nchar_done = s[0]; rx_nchar = n[0];
      #1;
      ev = exp_fct_valid(g_m, room);
      chk("R9", "fct_valid random", fct_valid, ev);
      if (f == 1 && cred_over(c_m, s) == 1) begin
        @(negedge clk);
        clear_inputs();
        chk("R8", "err_cred random", err_cred, 1);
        chk("R8", "link dropped on credit error", running, 0);
        @(negedge clk);
        chk("R8", "err_cred clears", err_cred, 0);
        bring_up();
      end else begin
        c_m = c_m + (f == 1 ? 8 : 0) - s;
        g_m = g_m + ((ev == 1 && rdy == 1) ? 8 : 0) - n;
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule